// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that steps on a qualified clock enable and restarts from zero each time it reaches a programmable 8-bit period value. The enable is one pulse per instruction cycle, which is a quarter of the oscillator rate. A selectable prescaler thins these pulses by 1, 4 or 16 before they reach the counter. Every period match gives a one-cycle pulse on an output port, so other logic can use it as a PWM time base or a serial clock source. The same match also steps a 4-bit postscaler, and each time the postscaler wraps it sets a sticky interrupt flag.

Software reaches the block through a small register port. A two-bit address picks the count, period or control register. A write strobe loads the picked register, and the read data always shows the register at the current address. A separate strobe clears the interrupt flag. A write to the count register or to the control register restarts both scalers. A control write leaves the count value as it is.

Top module: `period_timer`

## Requirements
- R1: After a synchronous reset the count reads 0x00, the period reads 0xFF, the control register reads 0x00, the timer is stopped and the interrupt flag is 0.
- R2: The control register (address 2) holds the postscale select in bits 6:3, the run enable in bit 2 and the prescale select in bits 1:0. Bit 7 always reads 0, whatever value was written.
- R3: Prescale select 00 advances the counter on every enable pulse, 01 on every 4th pulse and 1x on every 16th pulse. The pulses are counted from the last scaler clear.
- R4: The count (address 0) steps by one on each prescaled pulse. On a prescaled pulse that finds the count equal to the period, the count goes to 0, and `match_pulse` is high for exactly the following cycle.
- R5: The flag sets on the (N+1)-th period match after a scaler clear, where N is the 4-bit postscale select. The postscaler then restarts.
- R6: The interrupt flag stays set until `flag_clr` is asserted. If a postscaler wrap and a clear fall in the same cycle, the flag ends set.
- R7: A write to the count register loads the written value and clears both scaler counters. The counter does not advance in that cycle.
- R8: A write to the control register clears both scaler counters and leaves the count value unchanged. The counter does not advance in that cycle.
- R9: While the run enable is 0, the count, the prescaler and the postscaler hold their values.
- R10: A write to the period register (address 1) updates the period without clearing either scaler. A prescaled pulse in that same cycle compares against the old period.
- R11: Reading address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Instruction-rate clock enable (oscillator / 4) |
| reg_addr | input | 2 | Register select: 0 count, 1 period, 2 control, 3 none |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| match_pulse | output | 1 | One-cycle pulse after each period match |
| irq_flag | output | 1 | Sticky interrupt flag set by the postscaler |

## Verification
Some rules are checked by assertions on every cycle. The prescaler never fires while the timer is stopped or no enable pulse arrives. A scaler clear always leaves the prescale count at zero. A match pulse always finds the count at zero. The count holds in any cycle with no load and no advance. The flag is set after each postscaler wrap, and it holds until cleared. Other rules can only be shown by the bench's scenarios: the exact division ratios, the number of matches before the flag sets, the restart after count and control writes, and the order of events around a period change. For these the bench compares against a cycle model driven by mixed random and directed traffic.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 4;
    localparam int POST_W = 4;

    typedef enum logic [1:0] {
        ADDR_COUNT  = 2'd0,
        ADDR_PERIOD = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              rsvd;
        logic [POST_W-1:0] post_sel;
        logic              run;
        logic [1:0]        pre_sel;
    } ctrl_t;

    // terminal value of the prescale counter for a given select code
    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
        logic [PRE_W-1:0] lim;
        case (sel)
            2'b00:   lim = PRE_W'(0);
            2'b01:   lim = PRE_W'(3);
            default: lim = PRE_W'(15);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler
    import period_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       run,
    input  logic [1:0] pre_sel,
    input  logic       scaler_clr,
    output logic       adv
);
    logic [PRE_W-1:0] pre_q;
    logic             at_lim;

    assign at_lim = (pre_q == pre_limit(pre_sel));
    assign adv    = run && tick_en && !scaler_clr && at_lim;

    always_ff @(posedge clk) begin
        if (rst || scaler_clr) begin
            pre_q <= '0;
        end else if (run && tick_en) begin
            pre_q <= at_lim ? '0 : pre_q + 1'b1;
        end
    end

    assert_adv_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !(run && tick_en) |-> !adv);

    assert_clr_zeroes_R7: assert property (@(posedge clk) disable iff (rst)
        scaler_clr |=> pre_q == '0);

endmodule

// File: rtl/pt_counter.sv
module pt_counter
    import period_timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         hit,
    output logic         match_q
);
    logic [W-1:0] cnt_q;

    assign hit   = adv && !load && (cnt_q == period);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
            if (load)
                cnt_q <= load_val;
            else if (adv)
                cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    assert_match_wraps_R4: assert property (@(posedge clk) disable iff (rst)
        match_q |-> cnt_q == '0);

    assert_count_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/pt_postscaler.sv
module pt_postscaler
    import period_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [POST_W-1:0] post_sel,
    input  logic              scaler_clr,
    input  logic              flag_clr,
    output logic              flag
);
    logic [POST_W-1:0] post_q;
    logic              wrap;

    assign wrap = hit && !scaler_clr && (post_q == post_sel);

    always_ff @(posedge clk) begin
        if (rst || scaler_clr) begin
            post_q <= '0;
        end else if (hit) begin
            post_q <= wrap ? '0 : post_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (wrap)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

endmodule

// File: rtl/period_timer.sv
module period_timer
    import period_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             flag_clr,
    output logic             match_pulse,
    output logic             irq_flag
);
    localparam logic [CNT_W-1:0] PERIOD_RST = '1;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count;
    logic             wr_count, wr_period, wr_ctrl;
    logic             scaler_clr;
    logic             adv, hit;
    reg_addr_e        addr;

    assign addr       = reg_addr_e'(reg_addr);
    assign wr_count   = reg_wr && (addr == ADDR_COUNT);
    assign wr_period  = reg_wr && (addr == ADDR_PERIOD);
    assign wr_ctrl    = reg_wr && (addr == ADDR_CTRL);
    assign scaler_clr = wr_count || wr_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= PERIOD_RST;
        end else begin
            if (wr_ctrl) begin
                ctrl_q      <= ctrl_t'(reg_wdata);
                ctrl_q.rsvd <= 1'b0;
            end
            if (wr_period)
                period_q <= reg_wdata;
        end
    end

    always_comb begin
        case (addr)
            ADDR_COUNT:  reg_rdata = count;
            ADDR_PERIOD: reg_rdata = period_q;
            ADDR_CTRL:   reg_rdata = ctrl_q;
            default:     reg_rdata = '0;
        endcase
    end

    pt_prescaler u_pre (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .run        (ctrl_q.run),
        .pre_sel    (ctrl_q.pre_sel),
        .scaler_clr (scaler_clr),
        .adv        (adv)
    );

    pt_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .load     (wr_count),
        .load_val (reg_wdata),
        .period   (period_q),
        .count    (count),
        .hit      (hit),
        .match_q  (match_pulse)
    );

    pt_postscaler u_post (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .post_sel   (ctrl_q.post_sel),
        .scaler_clr (scaler_clr),
        .flag_clr   (flag_clr),
        .flag       (irq_flag)
    );

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ctrl_q.rsvd == 1'b0);

endmodule

// File: tb/period_timer_test.sv
module period_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [1:0] reg_addr = 2'd3;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       flag_clr = 1'b0;
    logic [7:0] reg_rdata;
    logic       match_pulse;
    logic       irq_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_cnt, m_per, m_ctl;
    logic [3:0] m_pre, m_post;
    logic       m_flag, m_match;
    logic [7:0] seen_rd;
    logic       seen_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    period_timer uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flag_clr(flag_clr), .match_pulse(match_pulse), .irq_flag(irq_flag)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] lim_of(logic [1:0] s);
        return (s == 2'b00) ? 4'd0 : (s == 2'b01) ? 4'd3 : 4'd15;
    endfunction

    function automatic logic [7:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_per;
            2'd2: return m_ctl;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 8'h00; m_per = 8'hFF; m_ctl = 8'h00;
        m_pre = 4'd0; m_post = 4'd0; m_flag = 1'b0; m_match = 1'b0;
    endtask

    task automatic model_step(logic w, logic [1:0] a, logic [7:0] d, logic t, logic c);
        logic inc, hit, ev;
        inc = 1'b0; hit = 1'b0; ev = 1'b0;
        if (w && a == 2'd0) begin
            m_cnt = d; m_pre = 4'd0; m_post = 4'd0;
        end else if (w && a == 2'd2) begin
            m_ctl = d & 8'h7F; m_pre = 4'd0; m_post = 4'd0;
        end else begin
            if (m_ctl[2] && t) begin
                if (m_pre == lim_of(m_ctl[1:0])) begin
                    m_pre = 4'd0; inc = 1'b1;
                end else m_pre = m_pre + 4'd1;
            end
            if (inc) begin
                if (m_cnt == m_per) begin m_cnt = 8'h00; hit = 1'b1; end
                else m_cnt = m_cnt + 8'd1;
            end
            if (hit) begin
                if (m_post == m_ctl[6:3]) begin m_post = 4'd0; ev = 1'b1; end
                else m_post = m_post + 4'd1;
            end
            if (w && a == 2'd1) m_per = d;
        end
        m_flag  = ev ? 1'b1 : (c ? 1'b0 : m_flag);
        m_match = hit;
    endtask

    // one clock: drive, compare pre-edge outputs against the model, advance model
    task automatic step(logic w, logic [1:0] a, logic [7:0] d, logic t, logic c);
        string rtag;
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; tick_en = t; flag_clr = c;
        #1;
        seen_rd = reg_rdata;
        seen_flag = irq_flag;
        rtag = (a == 2'd0) ? "R4 count" : (a == 2'd1) ? "R10 period" :
               (a == 2'd2) ? "R2 control" : "R11 unmapped";
        check(rtag, reg_rdata, model_read(a));
        check("R4 match_pulse", {7'd0, match_pulse}, {7'd0, m_match});
        check("R6 irq_flag", {7'd0, irq_flag}, {7'd0, m_flag});
        model_step(w, a, d, t, c);
    endtask

    task automatic peek(logic [1:0] a);
        step(1'b0, a, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset values
        peek(2'd0); check("R1 count", seen_rd, 8'h00);
        peek(2'd1); check("R1 period", seen_rd, 8'hFF);
        peek(2'd2); check("R1 control", seen_rd, 8'h00);
        check("R1 flag", {7'd0, seen_flag}, 8'h00);

        // R2 bit 7 reads zero
        step(1'b1, 2'd2, 8'hFF, 1'b0, 1'b0);
        peek(2'd2); check("R2 rsvd bit", seen_rd, 8'h7F);
        // R11
        peek(2'd3); check("R11 addr3", seen_rd, 8'h00);

        // R3 prescale ratios, period 0xFF
        step(1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
        step(1'b1, 2'd2, 8'h05, 1'b0, 1'b0);     // run, 1:4
        repeat (8) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        peek(2'd0); check("R3 div4", seen_rd, 8'd2);
        step(1'b1, 2'd2, 8'h06, 1'b0, 1'b0);     // run, 1:16
        repeat (32) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        peek(2'd0); check("R3 div16", seen_rd, 8'd4);
        step(1'b1, 2'd2, 8'h04, 1'b0, 1'b0);     // run, 1:1
        repeat (5) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        peek(2'd0); check("R3 div1", seen_rd, 8'd9);

        // R8 control write keeps count
        step(1'b1, 2'd2, 8'h05, 1'b1, 1'b0);
        peek(2'd0); check("R8 count kept", seen_rd, 8'd9);

        // R7 count write restarts prescaler (1:4)
        repeat (2) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        step(1'b1, 2'd0, 8'h00, 1'b1, 1'b0);
        repeat (3) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        peek(2'd0); check("R7 no step yet", seen_rd, 8'd0);
        step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        peek(2'd0); check("R7 first step", seen_rd, 8'd1);

        // R9 stopped timer holds
        step(1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
        repeat (10) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        peek(2'd0); check("R9 hold", seen_rd, 8'd1);

        // R5 postscale 1:2, period 3, prescale 1:4 -> flag after 32 ticks
        step(1'b1, 2'd1, 8'h03, 1'b0, 1'b0);
        step(1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
        step(1'b1, 2'd2, 8'h0D, 1'b0, 1'b0);
        repeat (31) step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        peek(2'd3); check("R5 before", {7'd0, seen_flag}, 8'h00);
        step(1'b0, 2'd3, 8'h00, 1'b1, 1'b0);
        peek(2'd3); check("R5 set", {7'd0, seen_flag}, 8'h01);
        // R6 sticky, then clear
        repeat (4) peek(2'd3);
        check("R6 sticky", {7'd0, seen_flag}, 8'h01);
        step(1'b0, 2'd3, 8'h00, 1'b0, 1'b1);
        peek(2'd3); check("R6 cleared", {7'd0, seen_flag}, 8'h00);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic w, t, c;
            logic [1:0] a;
            logic [7:0] d;
            w = ($urandom % 12) == 0;
            a = 2'($urandom % 4);
            d = 8'($urandom);
            if (a == 2'd1) d = 8'($urandom % 6);
            if (a == 2'd2 && ($urandom % 4) != 0) d[2] = 1'b1;
            if (a == 2'd2) d[6:3] = 4'($urandom % 3);
            t = ($urandom % 4) != 0;
            c = ($urandom % 10) == 0;
            step(w, a, d, t, c);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule